// File: doc/BRIEF.md
# Retirement Bundle Signature Filter

This block sits beside the retirement stage of a core. For each bundle of instructions waiting to retire, it receives a wide control vector and a cycle-count delta. It folds them into a short signature and looks that signature up in two small fully associative tables at the same time. The first table holds signatures that are known to be faulty. The second holds signatures of bundles that have already been verified as correct.

A bundle whose signature is in the verified table retires in the same cycle. A signature in the faulty table raises an escalation instead, and this takes priority when both tables hold it. When neither table holds the signature, the block accepts the bundle and stalls further bundles. It then raises a request to an external checker core, which answers through a valid/ready verdict handshake. The verdict decides the outcome for the bundle and stores the signature in the matching table.

The faulty table can also be filled through a preload port. This is meant for known faulty signatures written in after reset, before traffic starts.

Top module: `retire_sig_filter`

## Requirements
- R1: After reset both tables are empty. `bundle_ready` is 1, and `retire_ok`, `escalate`, `chk_req` and `verdict_ready` are all 0.
- R2: Signature bit i is the XOR of every `bundle_ctrl` bit j with j mod SIG_W = i, and every `bundle_cycles` bit k with k mod SIG_W = i. With the defaults this is ctrl[63:32] ^ ctrl[31:0] ^ cycles. The signature is shown on `chk_sig` while `chk_req` is high.
- R3: When a bundle is offered in the idle state and its signature hits only the verified table, `retire_ok` is 1 in that same cycle and no checker request follows.
- R4: When the signature hits the faulty table, `escalate` is 1 in that same cycle and `retire_ok` is 0. This holds even if the verified table also holds the signature.
- R5: When the signature misses both tables, the bundle is consumed and `chk_req` is 1 from the next cycle. `bundle_ready` stays 0, and bundles offered meanwhile are ignored, until the verdict handshake completes.
- R6: A verdict with `verdict_ok`=1 gives `retire_ok`=1 in the handshake cycle and stores the signature in the verified table. A later bundle with that signature retires at once.
- R7: A verdict with `verdict_ok`=0 gives `escalate`=1 in the handshake cycle and stores the signature in the faulty table. A later bundle with that signature escalates at once.
- R8: A preload (`pre_valid`=1) writes `pre_sig` into the faulty table while idle. A preload offered while a checker request is outstanding is ignored.
- R9: Each table holds DEPTH entries and replaces them in round-robin order, so the (DEPTH+1)-th insertion evicts the oldest entry.
- R10: `verdict_ready` is 1 exactly while `chk_req` is 1. Until the handshake, `chk_req` and `chk_sig` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_valid | input | 1 | Preload strobe for the faulty table |
| pre_sig | input | SIG_W | Signature to preload |
| bundle_valid | input | 1 | A bundle is waiting to retire |
| bundle_ctrl | input | CTRL_W | Control vector of the bundle |
| bundle_cycles | input | CYC_W | Cycle-count delta of the bundle |
| bundle_ready | output | 1 | Block is idle and can judge a bundle |
| retire_ok | output | 1 | Bundle may retire |
| escalate | output | 1 | Bundle is faulty; retirement blocked |
| chk_req | output | 1 | Checker request outstanding |
| chk_sig | output | SIG_W | Signature under check |
| verdict_valid | input | 1 | Checker verdict present |
| verdict_ok | input | 1 | Verdict: 1 correct, 0 faulty |
| verdict_ready | output | 1 | Block accepts the verdict |

## Verification
Several rules are checked by assertions on every cycle:
- `retire_ok` and `escalate` are never high together.
- A request holds steady with the same signature until its verdict arrives.
- Retirement is stalled while a request is outstanding.
- Every unmatched accepted bundle is followed by a request.

Other behaviours depend on what the tables hold, so only the bench scenarios show them:
- The exact fold of the signature.
- Learning from verdicts.
- Faulty-over-verified priority.
- Preloads being dropped during a check.
- Round-robin eviction.

The bench shows these by comparing against a reference model.

// File: rtl/retire_sig_filter.sv
module retire_sig_filter #(
  parameter int CTRL_W = 64,
  parameter int CYC_W  = 32,
  parameter int SIG_W  = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_valid,
  input  logic [SIG_W-1:0]  pre_sig,
  input  logic              bundle_valid,
  input  logic [CTRL_W-1:0] bundle_ctrl,
  input  logic [CYC_W-1:0]  bundle_cycles,
  output logic              bundle_ready,
  output logic              retire_ok,
  output logic              escalate,
  output logic              chk_req,
  output logic [SIG_W-1:0]  chk_sig,
  input  logic              verdict_valid,
  input  logic              verdict_ok,
  output logic              verdict_ready
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SIG_W-1:0] bad_tab  [DEPTH];
  logic [SIG_W-1:0] good_tab [DEPTH];
  logic [DEPTH-1:0] bad_vld, good_vld, bad_hitv, good_hitv;
  logic [IDX_W-1:0] bad_ptr, good_ptr;
  logic             waiting;
  logic [SIG_W-1:0] pend_sig, sig;

  always_comb begin
    sig = '0;
    for (int j = 0; j < CTRL_W; j++) sig[j % SIG_W] = sig[j % SIG_W] ^ bundle_ctrl[j];
    for (int k = 0; k < CYC_W; k++)  sig[k % SIG_W] = sig[k % SIG_W] ^ bundle_cycles[k];
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign bad_hitv[e]  = bad_vld[e]  && (bad_tab[e]  == sig);
    assign good_hitv[e] = good_vld[e] && (good_tab[e] == sig);
  end

  wire bad_hit  = |bad_hitv;
  wire good_hit = |good_hitv;
  wire offer    = bundle_valid && !waiting;
  wire handshake = verdict_valid && waiting;
  wire miss     = offer && !bad_hit && !good_hit;
  wire pre_wr   = pre_valid && !waiting;
  wire bad_wr   = pre_wr || (handshake && !verdict_ok);
  wire good_wr  = handshake && verdict_ok;
  wire [SIG_W-1:0] bad_wdata = waiting ? pend_sig : pre_sig;

  assign bundle_ready  = !waiting;
  assign chk_req       = waiting;
  assign verdict_ready = waiting;
  assign chk_sig       = pend_sig;
  assign retire_ok     = (offer && good_hit && !bad_hit) || good_wr;
  assign escalate      = (offer && bad_hit) || (handshake && !verdict_ok);

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting  <= 1'b0;
      pend_sig <= '0;
      bad_vld  <= '0;
      good_vld <= '0;
      bad_ptr  <= '0;
      good_ptr <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        bad_tab[e]  <= '0;
        good_tab[e] <= '0;
      end
    end else begin
      if (miss) begin
        waiting  <= 1'b1;
        pend_sig <= sig;
      end else if (handshake) begin
        waiting <= 1'b0;
      end
      if (bad_wr) begin
        bad_tab[bad_ptr] <= bad_wdata;
        bad_vld[bad_ptr] <= 1'b1;
        bad_ptr          <= bump(bad_ptr);
      end
      if (good_wr) begin
        good_tab[good_ptr] <= pend_sig;
        good_vld[good_ptr] <= 1'b1;
        good_ptr           <= bump(good_ptr);
      end
    end
  end
endmodule

// File: rtl/retire_sig_filter_chk.sv
module retire_sig_filter_chk #(
  parameter int SIG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bundle_valid,
  input logic             bundle_ready,
  input logic             retire_ok,
  input logic             escalate,
  input logic             chk_req,
  input logic [SIG_W-1:0] chk_sig,
  input logic             verdict_valid,
  input logic             verdict_ready
);
  AST_NO_DOUBLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_ok && escalate)); // R4
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && !verdict_valid |=> chk_req && $stable(chk_sig)); // R10
  AST_VRDY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_ready == chk_req); // R10
  AST_STALL_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> !bundle_ready && !(retire_ok && !verdict_valid)); // R5
  AST_MISS_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    bundle_valid && bundle_ready && !retire_ok && !escalate |=> chk_req); // R5
  AST_RETIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ok |-> (bundle_valid && bundle_ready) || (verdict_valid && verdict_ready)); // R3
  AST_HIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bundle_valid && bundle_ready && retire_ok |=> !chk_req); // R3
endmodule

bind retire_sig_filter retire_sig_filter_chk #(.SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bundle_valid(bundle_valid), .bundle_ready(bundle_ready),
  .retire_ok(retire_ok), .escalate(escalate), .chk_req(chk_req), .chk_sig(chk_sig),
  .verdict_valid(verdict_valid), .verdict_ready(verdict_ready)
);

// File: tb/retire_sig_filter_bench.sv
module retire_sig_filter_bench;
  logic        clk = 0, rst_n = 0;
  logic        pre_valid = 0, bundle_valid = 0, verdict_valid = 0, verdict_ok = 0;
  logic [31:0] pre_sig = 0, bundle_cycles = 0;
  logic [63:0] bundle_ctrl = 0;
  logic        bundle_ready, retire_ok, escalate, chk_req, verdict_ready;
  logic [31:0] chk_sig;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  retire_sig_filter u_retire_sig_filter (.*);

  logic [31:0] m_bad[16], m_good[16];
  bit          m_badv[16], m_goodv[16];
  int          m_bp = 0, m_gp = 0, m_st = 0;
  logic [31:0] m_pend = 0;

  function automatic logic [31:0] mk(input logic [63:0] c, input logic [31:0] y);
    return c[63:32] ^ c[31:0] ^ y;
  endfunction

  task automatic cmp(input string tag, input string nm, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, a, e);
    end
  endtask

  task automatic step(input bit bv, input logic [63:0] c, input logic [31:0] y,
                      input bit pv, input logic [31:0] ps, input bit vv, input bit vo,
                      input string tag);
    logic [31:0] s;
    bit bh, gh, e_ret, e_esc;
    bundle_valid = bv; bundle_ctrl = c; bundle_cycles = y;
    pre_valid = pv; pre_sig = ps; verdict_valid = vv; verdict_ok = vo;
    s = mk(c, y); bh = 0; gh = 0;
    foreach (m_bad[i])  if (m_badv[i]  && m_bad[i]  == s) bh = 1;
    foreach (m_good[i]) if (m_goodv[i] && m_good[i] == s) gh = 1;
    if (m_st == 0) begin e_ret = bv && gh && !bh; e_esc = bv && bh; end
    else begin e_ret = vv && vo; e_esc = vv && !vo; end
    #2;
    cmp(tag, "bundle_ready", 32'(bundle_ready), 32'(m_st == 0));
    cmp(tag, "chk_req", 32'(chk_req), 32'(m_st == 1));
    cmp(tag, "verdict_ready", 32'(verdict_ready), 32'(m_st == 1));
    cmp(tag, "retire_ok", 32'(retire_ok), 32'(e_ret));
    cmp(tag, "escalate", 32'(escalate), 32'(e_esc));
    if (m_st == 1) cmp(tag, "chk_sig", chk_sig, m_pend);
    @(posedge clk);
    if (m_st == 0) begin
      if (pv) begin m_bad[m_bp] = ps; m_badv[m_bp] = 1; m_bp = (m_bp + 1) % 16; end
      if (bv && !bh && !gh) begin m_pend = s; m_st = 1; end
    end else if (vv) begin
      if (vo) begin m_good[m_gp] = m_pend; m_goodv[m_gp] = 1; m_gp = (m_gp + 1) % 16; end
      else begin m_bad[m_bp] = m_pend; m_badv[m_bp] = 1; m_bp = (m_bp + 1) % 16; end
      m_st = 0;
    end
    @(negedge clk);
    bundle_valid = 0; pre_valid = 0; verdict_valid = 0;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [63:0] CA = 64'h1234_5678_9abc_def0;
  localparam logic [63:0] CB = 64'h0f0f_0000_00f0_ffff;
  localparam logic [63:0] CC = 64'hdead_beef_0000_0001;
  localparam logic [63:0] CD = 64'h0000_0042_0000_0000;
  localparam logic [63:0] CE = 64'h5555_aaaa_3333_cccc;

  initial begin
    foreach (m_bad[i]) begin m_badv[i] = 0; m_goodv[i] = 0; m_bad[i] = 0; m_good[i] = 0; end
    repeat (3) @(negedge clk);
    #2;
    cmp("R1", "ready_in_reset", 32'(bundle_ready), 1);
    rst_n = 1;
    @(negedge clk);
    idle("R1");
    // R5 R2: first bundle misses, stalls; offers during wait ignored
    step(1, CA, 32'd7, 0, 0, 0, 0, "R5");
    step(1, CB, 32'd1, 0, 0, 0, 0, "R5");
    cmp("R2", "chk_sig_fold", chk_sig, 32'h1234_5678 ^ 32'h9abc_def0 ^ 32'd7);
    idle("R10");
    step(0, 0, 0, 0, 0, 1, 1, "R6");
    step(1, CA, 32'd7, 0, 0, 0, 0, "R3");
    idle("R3");
    // R8 R4: preload then hit
    step(0, 0, 0, 1, mk(CB, 32'd3), 0, 0, "R8");
    step(1, CB, 32'd3, 0, 0, 0, 0, "R4");
    // R7
    step(1, CC, 32'd9, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(1, CC, 32'd9, 0, 0, 0, 0, "R7");
    // R4 priority: verified then preloaded as faulty
    step(1, CD, 32'd2, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 1, "R4");
    step(1, CD, 32'd2, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, mk(CD, 32'd2), 0, 0, "R4");
    step(1, CD, 32'd2, 0, 0, 0, 0, "R4");
    // R8: preload while waiting is dropped
    step(1, CE, 32'd5, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, mk(CE, 32'd6), 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    step(1, CE, 32'd6, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    // R9: fill verified table past capacity; oldest entry evicted
    for (int n = 0; n < 16; n++) begin
      step(1, 64'(n) << 40, 32'd100 + 32'(n), 0, 0, 0, 0, "R9");
      step(0, 0, 0, 0, 0, 1, 1, "R9");
    end
    step(1, CA, 32'd7, 0, 0, 0, 0, "R9");
    cmp("R9", "evicted_requests", 32'(chk_req), 1);
    step(0, 0, 0, 0, 0, 1, 1, "R9");
    step(1, 64'd15 << 40, 32'd115, 0, 0, 0, 0, "R9");
    idle("R1");
    finish_run();
  end
endmodule